// File: doc/BRIEF.md
# Frequency-Locked-Loop Lock Detector

This block decides whether a frequency-locked loop has settled by watching the correction pulses the loop emits. There are two correction directions, speed up and slow down. The block samples both on a monitor clock. While the preceding successive-approximation search reports that it has finished, the block looks for correction edges that arrive close together. Once it is locked, it looks for a correction that stays active in one direction for several cycles in a row.

Acquisition works by counting edges. The first rising edge in a direction opens a window. A second rising edge in the same direction inside that window declares lock. A 2-bit window code selects a short or a long window. Loss of lock works on levels. A run of consecutive high samples in one direction drops the flag. A single low sample restarts that run. The run may happen at any time while the block is locked. The enable input holds everything idle and keeps the flag low.

Top module: `fll_lock_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, `locked` is 0 after that edge. All acquisition and run state is cleared.
- R2: When `enable` is 0 at a clock edge, `locked` is 0 after that edge. All partial acquisition and run progress is discarded.
- R3: Edges are counted only in cycles where `sar_done` is 1. When `sar_done` is 0, rising edges on either correction input cannot cause lock, and any open window is dropped.
- R4: While unlocked and armed, a rising edge is a sample of 1 whose previous sample was 0. A second rising edge in the same direction as the first, inside the window, sets `locked` to 1 after the edge where it is sampled. The two edges need not be adjacent.
- R5: The count for `corr_up` and the count for `corr_down` are kept apart. One rising edge in each direction does not cause lock.
- R6: With `win_code` = 2'b00, the window is 6 cycles. A second edge 6 cycles after the first locks. A second edge 7 cycles after the first does not.
- R7: With `win_code` = 2'b01, 2'b10 or 2'b11, the window is 8 cycles. A second edge 8 cycles after the first locks. A second edge 9 cycles after the first does not.
- R8: When the window expires without a qualifying edge, the counts clear. The next rising edge then opens a new window.
- R9: While locked, `locked` falls to 0 after the edge where either `corr_up` or `corr_down` has been sampled high for 4 consecutive locked cycles.
- R10: A single low sample in a direction restarts that direction's run. Two high runs of 3 separated by one low sample keep `locked` at 1.
- R11: After the flag drops, acquisition re-arms from empty counts. A new pair of same-direction edges locks again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampled monitor clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle and unlocked |
| sar_done | input | 1 | Search-complete flag; arms acquisition while high |
| win_code | input | 2 | Window select: 2'b00 short window, other codes long window |
| corr_up | input | 1 | Speed-up correction pulse |
| corr_down | input | 1 | Slow-down correction pulse |
| locked | output | 1 | Lock flag |

## Verification
Directed sequences place the second edge exactly at the last cycle of each window and one cycle past it. This separates an off-by-one window from a correct one for every code. A pair of edges in opposite directions shows whether the two directions share a count. Runs of 3, then a gap, then 3 show whether the run resets on a low sample. A search flag held low, and a dropped enable, show that these conditions gate acquisition. Long random stretches follow, with pulse trains and held levels mixed together. They reach windows that expire, windows reopened on the expiry edge, and unlocks in both directions, all compared cycle by cycle against a bench reference model.

// File: rtl/fll_lock_pkg.sv
// Package: shared direction indexing for the lock detector.
// Assumes exactly two correction directions, up and down.
package fll_lock_pkg;
    localparam int NDIR    = 2;
    localparam int DIR_UP  = 0;
    localparam int DIR_DN  = 1;
    typedef logic [NDIR-1:0] dir_vec_t;
endpackage

// File: rtl/fll_edge_sense.sv
// Module: fll_edge_sense
// Registers the previous sample of each correction input and flags rising
// edges. Assumes inputs are already synchronous to clk. The history
// registers track regardless of enable, so an edge is seen only when the
// input actually went from low to high.
module fll_edge_sense #(
    parameter int NDIR = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NDIR-1:0] level,
    output logic [NDIR-1:0] rise
);
    logic [NDIR-1:0] prev_q;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        // Hold last sample of this direction.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[d] <= 1'b0;
            else        prev_q[d] <= level[d];
        end
        // Rising edge: high now, low last cycle.
        assign rise[d] = level[d] & ~prev_q[d];
    end
endmodule

// File: rtl/fll_acq_window.sv
// Module: fll_acq_window
// Acquisition engine. The first rising edge opens a window of WIN_SHORT
// or WIN_LONG cycles, picked by the window code. Edges are counted per
// direction. Hit pulses when a direction reaches EDGE_NUM edges inside the
// window. Assumes WIN_LONG >= WIN_SHORT >= 1 and EDGE_NUM >= 1. All state
// clears when arm is low, on a hit, or when the window runs out.
module fll_acq_window #(
    parameter int NDIR      = 2,
    parameter int WIN_SHORT = 6,
    parameter int WIN_LONG  = 8,
    parameter int EDGE_NUM  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic [1:0]      win_code,
    input  logic [NDIR-1:0] rise,
    output logic            hit
);
    localparam int TW = $clog2(WIN_LONG + 1);
    localparam int CW = $clog2(EDGE_NUM + 1);

    logic [TW-1:0]   age_q;
    logic [TW-1:0]   win_len;
    logic [CW-1:0]   cnt_q [NDIR];
    logic [NDIR-1:0] hit_dir;
    logic            open_w;
    logic            expire;
    logic            clr;
    logic            start;

    // Window length from the code: only 2'b00 selects the short window.
    always_comb begin
        win_len = (win_code == 2'b00) ? TW'(WIN_SHORT) : TW'(WIN_LONG);
    end

    // Window status and control decode.
    always_comb begin
        open_w = (age_q != '0);
        expire = open_w && (age_q == win_len);
        hit    = arm && (|hit_dir);
        clr    = !arm || hit || expire;
        start  = !open_w && (|rise);
    end

    // Window age: 1 on the cycle after the opening edge, counts upward.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) age_q <= '0;
        else if (start)    age_q <= TW'(1);
        else if (open_w)   age_q <= age_q + TW'(1);
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_cnt
        // Direction qualifies when this edge completes its count.
        assign hit_dir[d] = rise[d] && (cnt_q[d] == CW'(EDGE_NUM - 1));

        // Per-direction edge count within the current window.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)       cnt_q[d] <= '0;
            else if (start || open_w) cnt_q[d] <= cnt_q[d] + CW'(rise[d]);
        end
    end
endmodule

// File: rtl/fll_run_track.sv
// Module: fll_run_track
// Loss-of-lock engine. Counts consecutive high samples per direction while
// active. Hit pulses on the sample that completes RUN_LEN in a row. Any low
// sample zeroes that direction's count. Assumes RUN_LEN >= 1.
module fll_run_track #(
    parameter int NDIR    = 2,
    parameter int RUN_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic [NDIR-1:0] level,
    output logic            hit
);
    localparam int RW = $clog2(RUN_LEN + 1);

    logic [RW-1:0]   run_q [NDIR];
    logic [NDIR-1:0] hit_dir;

    // Any direction completing its run ends the lock.
    always_comb begin
        hit = active && (|hit_dir);
    end

    for (genvar d = 0; d < NDIR; d++) begin : g_run
        assign hit_dir[d] = level[d] && (run_q[d] == RW'(RUN_LEN - 1));

        // Consecutive-high counter; cleared when idle or on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n || !active || hit) run_q[d] <= '0;
            else if (level[d])            run_q[d] <= run_q[d] + RW'(1);
            else                          run_q[d] <= '0;
        end
    end
endmodule

// File: rtl/fll_lock_detect.sv
// Module: fll_lock_detect (top)
// Lock flag for a frequency-locked loop. Acquisition is edge-counted in a
// programmable window and armed by the search-done flag. Loss of lock is a
// level run in one direction. Assumes all inputs are synchronous to clk.
module fll_lock_detect #(
    parameter int WIN_SHORT = 6,
    parameter int WIN_LONG  = 8,
    parameter int EDGE_NUM  = 2,
    parameter int RUN_LEN   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       sar_done,
    input  logic [1:0] win_code,
    input  logic       corr_up,
    input  logic       corr_down,
    output logic       locked
);
    import fll_lock_pkg::*;

    dir_vec_t corr_lvl;
    dir_vec_t corr_rise;
    logic     lock_q;
    logic     acq_arm;
    logic     acq_hit;
    logic     run_act;
    logic     run_hit;
    logic     rise_any;

    // Gather direction levels into one vector.
    always_comb begin
        corr_lvl         = '0;
        corr_lvl[DIR_UP] = corr_up;
        corr_lvl[DIR_DN] = corr_down;
    end

    // Engine gating: acquire while unlocked, track runs while locked.
    always_comb begin
        acq_arm  = enable && sar_done && !lock_q;
        run_act  = enable && lock_q;
        rise_any = |corr_rise;
    end

    fll_edge_sense #(.NDIR(NDIR)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .level (corr_lvl),
        .rise  (corr_rise)
    );

    fll_acq_window #(
        .NDIR      (NDIR),
        .WIN_SHORT (WIN_SHORT),
        .WIN_LONG  (WIN_LONG),
        .EDGE_NUM  (EDGE_NUM)
    ) acq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (acq_arm),
        .win_code (win_code),
        .rise     (corr_rise),
        .hit      (acq_hit)
    );

    fll_run_track #(
        .NDIR    (NDIR),
        .RUN_LEN (RUN_LEN)
    ) run_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (run_act),
        .level  (corr_lvl),
        .hit    (run_hit)
    );

    // Lock flag register: set by acquisition, cleared by a run or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) lock_q <= 1'b0;
        else if (lock_q)       lock_q <= !run_hit;
        else                   lock_q <= acq_hit;
    end

    assign locked = lock_q;
endmodule

// File: rtl/fll_lock_detect_chk.sv
// Module: fll_lock_detect_chk
// Temporal checks on the lock flag, bound into every fll_lock_detect.
module fll_lock_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic sar_done,
    input logic corr_up,
    input logic corr_down,
    input logic rise_any,
    input logic locked
);
    // R1: reset leaves the flag low.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !locked);

    // R2: disable forces the flag low on the next cycle.
    a_r2_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !locked);

    // R3: no lock can be gained while the search-done flag is low.
    a_r3_unarmed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !sar_done) |=> !locked);

    // R4: lock only ever rises right after a sampled rising edge.
    a_r4_lock_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(rise_any));

    // R9: an enabled unlock needs a correction level high on the last sample.
    a_r9_unlock_on_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(locked) && $past(enable)) |-> $past(corr_up || corr_down));
endmodule

bind fll_lock_detect fll_lock_detect_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sar_done  (sar_done),
    .corr_up   (corr_up),
    .corr_down (corr_down),
    .rise_any  (rise_any),
    .locked    (locked)
);

// File: tb/fll_lock_detect_tb_top.sv
`timescale 1ns/100ps
module fll_lock_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       sar_done = 1'b1;
    logic [1:0] win_code = 2'b00;
    logic       corr_up = 1'b0;
    logic       corr_down = 1'b0;
    logic       locked;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state.
    bit    m_lock, m_pu, m_pd, m_open;
    int    m_age, m_nu, m_nd, m_ru, m_rd;
    string m_tag;

    always #2.5 clk = ~clk;

    fll_lock_detect dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sar_done  (sar_done),
        .win_code  (win_code),
        .corr_up   (corr_up),
        .corr_down (corr_down),
        .locked    (locked)
    );

    function automatic int win_of(logic [1:0] c);
        return (c == 2'b00) ? 6 : 8;
    endfunction

    function automatic void acq_reset();
        m_open = 0; m_age = 0; m_nu = 0; m_nd = 0;
    endfunction

    // Advance the reference by one clock edge with the current inputs.
    function automatic void model_step();
        bit ru, rd;
        ru = corr_up && !m_pu;
        rd = corr_down && !m_pd;
        m_pu = corr_up; m_pd = corr_down;
        m_tag = m_lock ? "R9" : "R4";
        if (!rst_n) begin
            m_pu = 0; m_pd = 0; m_lock = 0; m_ru = 0; m_rd = 0; acq_reset();
            m_tag = "R1";
        end else if (!enable) begin
            m_lock = 0; m_ru = 0; m_rd = 0; acq_reset(); m_tag = "R2";
        end else if (m_lock) begin
            m_ru = corr_up ? m_ru + 1 : 0;
            m_rd = corr_down ? m_rd + 1 : 0;
            if (m_ru == 4 || m_rd == 4) begin
                m_lock = 0; m_ru = 0; m_rd = 0; acq_reset();
            end
        end else if (!sar_done) begin
            acq_reset(); m_tag = "R3";
        end else if (!m_open) begin
            if (ru || rd) begin
                m_open = 1; m_age = 1; m_nu = int'(ru); m_nd = int'(rd);
            end
        end else if ((ru && m_nu == 1) || (rd && m_nd == 1)) begin
            m_lock = 1; acq_reset();
        end else if (m_age == win_of(win_code)) begin
            acq_reset(); m_tag = "R8";
        end else begin
            m_age++; m_nu += int'(ru); m_nd += int'(rd);
        end
    endfunction

    task automatic check_lock(bit exp, string req);
        tests++;
        if (locked !== exp) begin
            fails++;
            $display("FAIL %s: locked=%0b expected %0b at %0t", req, locked, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, model the edge, compare at next negedge.
    task automatic cyc(bit u, bit d);
        corr_up = u; corr_down = d;
        model_step();
        @(negedge clk);
        check_lock(m_lock, m_tag);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(0, 0);
    endtask

    task automatic hold_up(int n);
        for (int k = 0; k < n; k++) cyc(1, 0);
    endtask

    initial begin
        int unused_seed;
        int hu, hd, r;
        unused_seed = $urandom(32'd20240611);
        @(negedge clk);
        // R1: reset
        rst_n = 0; idle(3);
        rst_n = 1; idle(1); check_lock(0, "R1");
        // R4: edges two cycles apart lock
        cyc(1, 0); cyc(0, 0); cyc(1, 0); check_lock(1, "R4");
        // R9: four high samples while locked unlock
        hold_up(3); check_lock(1, "R9"); hold_up(1); check_lock(0, "R9");
        // R11: re-arm and lock again
        cyc(0, 0); cyc(1, 0); cyc(0, 0); cyc(1, 0); check_lock(1, "R11");
        // R10: gap restarts run
        hold_up(2); cyc(0, 0); hold_up(3); check_lock(1, "R10");
        for (int k = 0; k < 4; k++) cyc(0, 1);
        check_lock(0, "R9");
        idle(1);
        // R6: short window, edge at offset 6 locks
        win_code = 2'b00;
        cyc(1, 0); idle(5); cyc(1, 0); check_lock(1, "R6");
        hold_up(4); check_lock(0, "R9"); idle(1);
        // R6 / R8: offset 7 misses and opens a new window
        cyc(1, 0); idle(6); cyc(1, 0); check_lock(0, "R6");
        cyc(0, 0); cyc(1, 0); check_lock(1, "R8");
        hold_up(4); idle(1);
        // R7: long window for codes 01, 11, 10
        win_code = 2'b01;
        cyc(1, 0); idle(7); cyc(1, 0); check_lock(1, "R7");
        hold_up(4); idle(1);
        win_code = 2'b11;
        cyc(1, 0); idle(8); cyc(1, 0); check_lock(0, "R7");
        idle(9);
        win_code = 2'b10;
        cyc(1, 0); idle(7); cyc(1, 0); check_lock(1, "R7");
        hold_up(4); idle(1);
        // R5: one edge each direction does not lock
        win_code = 2'b00;
        cyc(1, 0); cyc(0, 0); cyc(0, 1); check_lock(0, "R5");
        idle(8);
        // R3: no acquisition while search flag low
        sar_done = 0;
        cyc(1, 0); cyc(0, 0); cyc(1, 0); check_lock(0, "R3");
        cyc(0, 0);
        sar_done = 1;
        cyc(1, 0); cyc(0, 0); cyc(1, 0); check_lock(1, "R3");
        // R2: disable drops lock
        enable = 0; cyc(0, 0); check_lock(0, "R2");
        enable = 1; cyc(0, 0); check_lock(0, "R2");
        // Random phase compared against the model every cycle.
        hu = 0; hd = 0;
        for (int n = 0; n < 8000; n++) begin
            bit u, d;
            enable   = ($urandom % 80) != 0;
            sar_done = ($urandom % 20) != 0;
            if (($urandom % 50) == 0) win_code = 2'($urandom % 4);
            r = int'($urandom % 16);
            if (hu > 0) begin u = 1; hu--; end
            else if (r == 0) begin u = 1; hu = 2 + int'($urandom % 4); end
            else u = (r < 5);
            r = int'($urandom % 16);
            if (hd > 0) begin d = 1; hd--; end
            else if (r == 0) begin d = 1; hd = 2 + int'($urandom % 4); end
            else d = (r < 5);
            cyc(u, d);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule